// File: doc/BRIEF.md
# Strip Frame Hit Extractor

This block sits behind the digitiser of one strip readout chip and turns its raw sample stream into a short list of hit clusters. The chip sends frames, each made of a header word followed by one 10-bit sample per strip in a fixed strip order. The block locks onto the header and subtracts a per-strip pedestal from every sample. It buffers the frame and estimates the common-mode level as the mean of the pedestal-corrected samples. On a second pass it removes that level, compares each strip against a threshold, and merges runs of adjacent hit strips into cluster records.

A frame is only trusted once the header of the following frame arrives exactly where it should. A frame whose successor header is missing is discarded, a sync error is flagged, and the block hunts for a new header. Pedestals sit in an internal table that software fills through a simple write port before data taking.

Top module: `strip_hit_extractor`

## Requirements
- R1: While rst_ni is low and right after it rises, clu_valid_o and sync_err_o are low and the block is hunting for a header.
- R2: While hunting, valid samples other than the header word (all ones, 10'h3FF by default) are ignored; a valid header word opens a frame whose next 128 valid samples are strips 0 to 127 in that order.
- R3: A write with ped_we_i high stores ped_data_i as the pedestal of strip ped_addr_i; the difference of strip i is its sample minus that pedestal, as an unsigned-to-signed subtraction.
- R4: The common-mode level of a frame is the floor of the sum of its 128 differences divided by 128; the corrected value of a strip is its difference minus that level.
- R5: A strip is hit only when its corrected value is strictly greater than the signed thresh_i; a value equal to thresh_i is not a hit.
- R6: Each maximal run of consecutive hit strips inside one frame yields one record with the index of its lowest strip, the number of strips and the signed sum of their corrected values; records of a frame come out in rising strip order and a run never spans two frames.
- R7: A run that reaches strip 127 is closed at the end of the frame and reported like any other.
- R8: A frame is processed only after the valid sample that follows its strip 127 is found to be a header word; that same header opens the next frame.
- R9: If the sample following strip 127 is not a header word, sync_err_o is high for exactly one cycle, the frame produces no records, and the block hunts for a header again.
- R10: Frames may arrive back to back with a valid sample every cycle; processing runs one strip per cycle, and a record of one frame and the sync error of the next frame may be reported in the same cycle.
- R11: Cycles with sample_valid_i low neither advance the frame nor change its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_valid_i | input | 1 | sample_i carries a sample this cycle |
| sample_i | input | 10 | Digitised sample or header word |
| ped_we_i | input | 1 | Pedestal table write strobe |
| ped_addr_i | input | 7 | Strip index of the pedestal write |
| ped_data_i | input | 10 | Pedestal value to store |
| thresh_i | input | 12 | Signed hit threshold on corrected values |
| clu_valid_o | output | 1 | A cluster record is present this cycle |
| clu_first_o | output | 7 | Lowest strip index of the cluster |
| clu_width_o | output | 8 | Number of strips in the cluster |
| clu_sum_o | output | 19 | Signed sum of corrected values of the cluster |
| sync_err_o | output | 1 | One-cycle pulse on a missing header |

## Verification
The second pass over one frame overlaps the filling of the next frame, so the record closing a cluster on strip 127 of one frame is produced in the very cycle that the header check of the following frame is judged. The bench provokes this by sending a frame with a hit on its last strip, then a further frame back to back, then a wrong word where the next header belongs. It requires that the strip 127 record arrives intact, that sync_err_o pulses once in the same cycle as that record, and that the frame with the missing header yields nothing.

// File: rtl/sfx_pkg.sv
package sfx_pkg;

  typedef enum logic [1:0] {
    ST_HUNT  = 2'd0,
    ST_FILL  = 2'd1,
    ST_CHECK = 2'd2
  } cap_state_e;

endpackage

// File: rtl/sfx_ped_ram.sv
module sfx_ped_ram #(
  parameter int DW = 10,
  parameter int N  = 128
) (
  input  logic                 clk_i,
  input  logic                 we_i,
  input  logic [$clog2(N)-1:0] waddr_i,
  input  logic [DW-1:0]        wdata_i,
  input  logic [$clog2(N)-1:0] raddr_i,
  output logic [DW-1:0]        rdata_o
);

  logic [DW-1:0] mem_q [N];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];

endmodule

// File: rtl/sfx_frame_capture.sv
module sfx_frame_capture
  import sfx_pkg::*;
#(
  parameter int            DW       = 10,
  parameter int            N        = 128,
  parameter logic [DW-1:0] HDR_WORD = {DW{1'b1}},
  localparam int           IW       = $clog2(N),
  localparam int           DFW      = DW + 1,
  localparam int           SW       = DFW + IW
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  valid_i,
  input  logic [DW-1:0]         sample_i,
  input  logic [DW-1:0]         ped_i,
  output logic [IW-1:0]         idx_o,
  output logic                  wr_o,
  output logic signed [DFW-1:0] diff_o,
  output logic                  release_o,
  output logic signed [DFW-1:0] mean_o,
  output logic                  sync_err_o
);

  cap_state_e           state_q;
  logic [IW-1:0]        idx_q;
  logic signed [SW-1:0] acc_q;
  logic                 is_hdr;

  assign is_hdr = (sample_i == HDR_WORD);
  assign diff_o = $signed({1'b0, sample_i}) - $signed({1'b0, ped_i});
  assign wr_o   = valid_i && (state_q == ST_FILL);
  assign idx_o  = idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_HUNT;
      idx_q      <= '0;
      acc_q      <= '0;
      release_o  <= 1'b0;
      mean_o     <= '0;
      sync_err_o <= 1'b0;
    end else begin
      release_o  <= 1'b0;
      sync_err_o <= 1'b0;
      if (valid_i) begin
        unique case (state_q)
          ST_HUNT: begin
            if (is_hdr) begin
              state_q <= ST_FILL;
              idx_q   <= '0;
              acc_q   <= '0;
            end
          end
          ST_FILL: begin
            acc_q <= acc_q + $signed({{(SW-DFW){diff_o[DFW-1]}}, diff_o});
            idx_q <= idx_q + 1'b1;
            if (idx_q == IW'(N - 1)) state_q <= ST_CHECK;
          end
          ST_CHECK: begin
            acc_q <= '0;
            idx_q <= '0;
            if (is_hdr) begin
              // frame confirmed: hand over floor(sum / N), reopen at once
              release_o <= 1'b1;
              mean_o    <= DFW'(acc_q >>> IW);
              state_q   <= ST_FILL;
            end else begin
              sync_err_o <= 1'b1;
              state_q    <= ST_HUNT;
            end
          end
          default: state_q <= ST_HUNT;
        endcase
      end
    end
  end

endmodule

// File: rtl/sfx_cm_pass.sv
module sfx_cm_pass #(
  parameter int  DW  = 10,
  parameter int  N   = 128,
  localparam int IW  = $clog2(N),
  localparam int DFW = DW + 1,
  localparam int CW  = DW + 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_i,
  input  logic [IW-1:0]         widx_i,
  input  logic signed [DFW-1:0] wdiff_i,
  input  logic                  release_i,
  input  logic signed [DFW-1:0] mean_i,
  output logic                  s_vld_o,
  output logic [IW-1:0]         s_idx_o,
  output logic signed [CW-1:0]  s_cor_o,
  output logic                  s_last_o
);

  logic signed [DFW-1:0] mem_q [N];
  logic signed [DFW-1:0] cm_q, cm_cur, rd;
  logic [IW-1:0]         ridx_q, ridx;
  logic                  run_q, active;
  logic signed [CW-1:0]  cor;

  always_ff @(posedge clk_i) begin
    if (wr_i) mem_q[widx_i] <= wdiff_i;
  end

  // read starts in the release cycle so it stays ahead of the refill
  assign active = release_i | run_q;
  assign ridx   = run_q ? ridx_q : '0;
  assign cm_cur = release_i ? mean_i : cm_q;
  assign rd     = mem_q[ridx];
  assign cor    = $signed({{(CW-DFW){rd[DFW-1]}}, rd})
                - $signed({{(CW-DFW){cm_cur[DFW-1]}}, cm_cur});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cm_q     <= '0;
      ridx_q   <= '0;
      run_q    <= 1'b0;
      s_vld_o  <= 1'b0;
      s_idx_o  <= '0;
      s_cor_o  <= '0;
      s_last_o <= 1'b0;
    end else begin
      if (release_i) cm_q <= mean_i;
      if (active) begin
        ridx_q <= ridx + 1'b1;
        run_q  <= (ridx != IW'(N - 1));
      end
      s_vld_o  <= active;
      s_idx_o  <= ridx;
      s_cor_o  <= cor;
      s_last_o <= active && (ridx == IW'(N - 1));
    end
  end

endmodule

// File: rtl/sfx_cluster_builder.sv
module sfx_cluster_builder #(
  parameter int  N   = 128,
  parameter int  CW  = 12,
  localparam int IW  = $clog2(N),
  localparam int WW  = IW + 1,
  localparam int CSW = CW + IW
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  vld_i,
  input  logic [IW-1:0]         idx_i,
  input  logic signed [CW-1:0]  cor_i,
  input  logic                  last_i,
  input  logic signed [CW-1:0]  thresh_i,
  output logic                  clu_valid_o,
  output logic [IW-1:0]         clu_first_o,
  output logic [WW-1:0]         clu_width_o,
  output logic signed [CSW-1:0] clu_sum_o
);

  logic                  run_q, run_d;
  logic [IW-1:0]         first_q, first_d, e_first;
  logic [WW-1:0]         width_q, width_d, e_width;
  logic signed [CSW-1:0] sum_q, sum_d, e_sum, cor_ext;
  logic                  hit, emit;

  assign hit     = vld_i && (cor_i > thresh_i);
  assign cor_ext = $signed({{(CSW-CW){cor_i[CW-1]}}, cor_i});

  always_comb begin
    run_d   = run_q;
    first_d = first_q;
    width_d = width_q;
    sum_d   = sum_q;
    emit    = 1'b0;
    e_first = first_q;
    e_width = width_q;
    e_sum   = sum_q;
    if (vld_i) begin
      if (hit) begin
        if (run_q) begin
          width_d = width_q + 1'b1;
          sum_d   = sum_q + cor_ext;
        end else begin
          first_d = idx_i;
          width_d = WW'(1);
          sum_d   = cor_ext;
        end
        run_d = !last_i;
        if (last_i) begin
          emit    = 1'b1;
          e_first = first_d;
          e_width = width_d;
          e_sum   = sum_d;
        end
      end else if (run_q) begin
        emit  = 1'b1;
        run_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q       <= 1'b0;
      first_q     <= '0;
      width_q     <= '0;
      sum_q       <= '0;
      clu_valid_o <= 1'b0;
      clu_first_o <= '0;
      clu_width_o <= '0;
      clu_sum_o   <= '0;
    end else begin
      run_q       <= run_d;
      first_q     <= first_d;
      width_q     <= width_d;
      sum_q       <= sum_d;
      clu_valid_o <= emit;
      if (emit) begin
        clu_first_o <= e_first;
        clu_width_o <= e_width;
        clu_sum_o   <= e_sum;
      end
    end
  end

endmodule

// File: rtl/strip_hit_extractor.sv
module strip_hit_extractor #(
  parameter int            DATA_W   = 10,
  parameter int            N_STRIPS = 128,
  parameter logic [DATA_W-1:0] HDR_WORD = {DATA_W{1'b1}},
  localparam int           IW       = $clog2(N_STRIPS),
  localparam int           DFW      = DATA_W + 1,
  localparam int           CW       = DATA_W + 2,
  localparam int           WW       = IW + 1,
  localparam int           CSW      = CW + IW
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  sample_valid_i,
  input  logic [DATA_W-1:0]     sample_i,
  input  logic                  ped_we_i,
  input  logic [IW-1:0]         ped_addr_i,
  input  logic [DATA_W-1:0]     ped_data_i,
  input  logic signed [CW-1:0]  thresh_i,
  output logic                  clu_valid_o,
  output logic [IW-1:0]         clu_first_o,
  output logic [WW-1:0]         clu_width_o,
  output logic signed [CSW-1:0] clu_sum_o,
  output logic                  sync_err_o
);

  logic [IW-1:0]         cap_idx;
  logic [DATA_W-1:0]     ped_val;
  logic                  wr_w, rel_w;
  logic signed [DFW-1:0] diff_w, mean_w;
  logic                  s_vld, s_last;
  logic [IW-1:0]         s_idx;
  logic signed [CW-1:0]  s_cor;

  sfx_ped_ram #(.DW(DATA_W), .N(N_STRIPS)) u_ped (
    .clk_i   (clk_i),
    .we_i    (ped_we_i),
    .waddr_i (ped_addr_i),
    .wdata_i (ped_data_i),
    .raddr_i (cap_idx),
    .rdata_o (ped_val)
  );

  sfx_frame_capture #(.DW(DATA_W), .N(N_STRIPS), .HDR_WORD(HDR_WORD)) u_cap (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .valid_i    (sample_valid_i),
    .sample_i   (sample_i),
    .ped_i      (ped_val),
    .idx_o      (cap_idx),
    .wr_o       (wr_w),
    .diff_o     (diff_w),
    .release_o  (rel_w),
    .mean_o     (mean_w),
    .sync_err_o (sync_err_o)
  );

  sfx_cm_pass #(.DW(DATA_W), .N(N_STRIPS)) u_cm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr_w),
    .widx_i    (cap_idx),
    .wdiff_i   (diff_w),
    .release_i (rel_w),
    .mean_i    (mean_w),
    .s_vld_o   (s_vld),
    .s_idx_o   (s_idx),
    .s_cor_o   (s_cor),
    .s_last_o  (s_last)
  );

  sfx_cluster_builder #(.N(N_STRIPS), .CW(CW)) u_clu (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .vld_i       (s_vld),
    .idx_i       (s_idx),
    .cor_i       (s_cor),
    .last_i      (s_last),
    .thresh_i    (thresh_i),
    .clu_valid_o (clu_valid_o),
    .clu_first_o (clu_first_o),
    .clu_width_o (clu_width_o),
    .clu_sum_o   (clu_sum_o)
  );

endmodule

// File: rtl/sfx_checker.sv
module sfx_checker #(
  parameter int  N  = 128,
  localparam int IW = $clog2(N),
  localparam int WW = IW + 1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          rel_i,
  input logic          s_vld_i,
  input logic [IW-1:0] s_idx_i,
  input logic          s_last_i,
  input logic          clu_valid_i,
  input logic [IW-1:0] clu_first_i,
  input logic [WW-1:0] clu_width_i,
  input logic          sync_err_i
);

  AST_ERR_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_err_i |=> !sync_err_i); // R9

  AST_CLU_IN_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clu_valid_i |-> (clu_width_i != '0) && (({1'b0, clu_first_i} + clu_width_i) <= N)); // R6

  AST_RELEASE_STARTS_SCAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rel_i |=> s_vld_i && (s_idx_i == '0)); // R8

  AST_STRIP_PER_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s_vld_i && !s_last_i) |=> s_vld_i && (s_idx_i == $past(s_idx_i) + 1'b1)); // R10

  AST_NO_RELEASE_MID_SCAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s_vld_i && !s_last_i) |-> !rel_i); // R10

endmodule

bind strip_hit_extractor sfx_checker #(.N(N_STRIPS)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rel_i       (rel_w),
  .s_vld_i     (s_vld),
  .s_idx_i     (s_idx),
  .s_last_i    (s_last),
  .clu_valid_i (clu_valid_o),
  .clu_first_i (clu_first_o),
  .clu_width_i (clu_width_o),
  .sync_err_i  (sync_err_o)
);

// File: tb/test_strip_hit_extractor.sv
module test_strip_hit_extractor;

  localparam int N   = 128;
  localparam int NV  = 7;
  localparam int HDR = 10'h3FF;
  // base offset, first strip, width, amplitude, expected sum
  localparam int VEC [NV][5] = '{
    '{  0,  10,  3,  40, 120},
    '{  5,   0,  1,  50,  50},
    '{-30,  60,  4, 100, 388},
    '{ 12, 120,  8,  30, 232},
    '{  0, 127,  1,  90,  90},
    '{-50,  33, 16,  64, 896},
    '{  3,  90,  2,  21,  42}
  };

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               vld = 1'b0;
  logic [9:0]         smp = '0;
  logic               ped_we = 1'b0;
  logic [6:0]         ped_addr = '0;
  logic [9:0]         ped_data = '0;
  logic signed [11:0] thr = 12'sd20;
  logic               clu_valid;
  logic [6:0]         clu_first;
  logic [7:0]         clu_width;
  logic signed [18:0] clu_sum;
  logic               sync_err;

  strip_hit_extractor i_strip_hit_extractor (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .sample_valid_i (vld),
    .sample_i       (smp),
    .ped_we_i       (ped_we),
    .ped_addr_i     (ped_addr),
    .ped_data_i     (ped_data),
    .thresh_i       (thr),
    .clu_valid_o    (clu_valid),
    .clu_first_o    (clu_first),
    .clu_width_o    (clu_width),
    .clu_sum_o      (clu_sum),
    .sync_err_o     (sync_err)
  );

  always #2ns clk = ~clk;

  int     ped_m [N];
  int     amp_a [N];
  int     rec_first [64];
  int     rec_width [64];
  int     rec_sum [64];
  longint rec_cyc [64];
  int     rec_n = 0;
  int     err_n = 0;
  longint err_cyc = -1;
  longint cyc = 0;
  int     checks = 0;
  int     fails = 0;
  bit     done = 1'b0;

  always @(posedge clk) cyc++;

  always @(negedge clk) begin
    if (rst_n) begin
      if (clu_valid) begin
        if (rec_n < 64) begin
          rec_first[rec_n] = int'(clu_first);
          rec_width[rec_n] = int'(clu_width);
          rec_sum[rec_n]   = int'(clu_sum);
          rec_cyc[rec_n]   = cyc;
        end
        rec_n++;
      end
      if (sync_err) begin
        err_n++;
        err_cyc = cyc;
      end
    end
  end

  task automatic check(string req, string what, longint act, longint exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic chk_rec(string req, int k, int f, int w, int s);
    int af, aw, as;
    checks++;
    af = -1; aw = -1; as = -1;
    if (k < rec_n && k < 64) begin
      af = rec_first[k]; aw = rec_width[k]; as = rec_sum[k];
    end
    if (af != f || aw != w || as != s) begin
      fails++;
      $display("FAIL %s record %0d: actual (%0d,%0d,%0d) expected (%0d,%0d,%0d)",
               req, k, af, aw, as, f, w, s);
    end
  endtask

  task automatic drive(int w);
    @(negedge clk);
    vld = 1'b1;
    smp = w[9:0];
  endtask

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      vld = 1'b0;
    end
  endtask

  task automatic clear_amp();
    for (int i = 0; i < N; i++) amp_a[i] = 0;
  endtask

  task automatic set_run(int f, int w, int a);
    for (int i = f; i < f + w; i++) amp_a[i] = a;
  endtask

  task automatic send_strips(int base, bit gaps);
    for (int i = 0; i < N; i++) begin
      drive(ped_m[i] + base + amp_a[i]);
      if (gaps) idle(1);
    end
  endtask

  function automatic string vec_tag(int v);
    string s = "R3/R4/R6";
    if (v % 2 == 1) s = {s, "/R11"};
    else s = {s, "/R10"};
    if (v == 4) s = {s, "/R7"};
    if (v == 6) s = {s, "/R5"};
    return s;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int r0, e0;
    for (int i = 0; i < N; i++) ped_m[i] = 100 + (i * 7) % 32;

    // reset
    repeat (3) @(negedge clk);
    check("R1", "clu_valid_o in reset", longint'(clu_valid), 0);
    check("R1", "sync_err_o in reset", longint'(sync_err), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "clu_valid_o after reset", longint'(clu_valid), 0);

    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      ped_we = 1'b1; ped_addr = 7'(i); ped_data = 10'(ped_m[i]);
    end
    @(negedge clk);
    ped_we = 1'b0;

    // junk before any header must be ignored
    repeat (20) drive(5);
    idle(150);
    check("R2", "records before header", rec_n, 0);
    check("R2", "sync errors before header", err_n, 0);

    // table walk
    for (int v = 0; v < NV; v++) begin
      clear_amp();
      set_run(VEC[v][1], VEC[v][2], VEC[v][3]);
      drive(HDR);
      send_strips(VEC[v][0], v % 2 == 1);
    end
    drive(HDR);
    idle(140);
    check("R8", "record count of table", rec_n, NV);
    for (int v = 0; v < NV; v++)
      chk_rec(vec_tag(v), v, VEC[v][1], VEC[v][2], VEC[v][4]);

    // corrected value equal to threshold is not a hit
    r0 = rec_n;
    clear_amp();
    set_run(70, 2, 20);
    send_strips(0, 1'b0);
    drive(HDR);
    idle(140);
    check("R5", "records at threshold", rec_n - r0, 0);

    // two runs in one frame, nonzero common mode
    r0 = rec_n;
    clear_amp();
    set_run(5, 2, 50);
    set_run(9, 1, 60);
    send_strips(-7, 1'b0);
    drive(HDR);
    idle(140);
    check("R6", "records of two-run frame", rec_n - r0, 2);
    chk_rec("R4/R6", r0, 5, 2, 98);
    chk_rec("R4/R6", r0 + 1, 9, 1, 59);

    // last-strip record coinciding with sync error of next frame
    r0 = rec_n;
    e0 = err_n;
    clear_amp();
    set_run(127, 1, 90);
    send_strips(0, 1'b0);
    drive(HDR);
    clear_amp();
    set_run(50, 1, 80);
    send_strips(0, 1'b0);
    drive(0);
    idle(140);
    check("R9", "sync error pulses", err_n - e0, 1);
    check("R9", "records incl. dropped frame", rec_n - r0, 1);
    chk_rec("R7/R10", r0, 127, 1, 90);
    check("R10", "record cycle vs error cycle", (r0 < 64) ? rec_cyc[r0] : -1, err_cyc);

    // recovery after sync error
    r0 = rec_n;
    repeat (3) drive(5);
    drive(HDR);
    clear_amp();
    set_run(100, 3, 33);
    send_strips(0, 1'b0);
    drive(HDR);
    idle(140);
    check("R9", "records after resync", rec_n - r0, 1);
    chk_rec("R2/R9", r0, 100, 3, 99);

    // pedestal rewrite moves one strip above threshold
    r0 = rec_n;
    @(negedge clk);
    ped_we = 1'b1; ped_addr = 7'd40; ped_data = 10'(ped_m[40] - 50);
    @(negedge clk);
    ped_we = 1'b0;
    clear_amp();
    send_strips(0, 1'b0);
    drive(HDR);
    idle(140);
    check("R3", "records after pedestal write", rec_n - r0, 1);
    chk_rec("R3", r0, 40, 1, 50);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule